// File: doc/BRIEF.md
# Program Counter Sequencer

This block owns the program counter of a single-cycle processor core. Once per clock it picks the next fetch address from one of several sources and registers it. The sources are the sequential successor, a PC-relative branch target, an absolute in-region jump target, a register-supplied jump target, and three fixed trap addresses for power-up, an undefined opcode and an external interrupt.

The control decoder supplies a 3-bit source code. It also supplies the ALU zero flag and the polarity of the branch under way (equal or not-equal). The instruction word supplies its 16-bit offset field and its 26-bit jump index. The register file supplies the first read operand.

The block drives two outputs. The current PC goes to the instruction memory address. PC+4 goes to the register write-back path, where link instructions use it. The branch target has its own adder, so the ALU stays free to do the compare subtraction.

Top module: `pc_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, `pc_o` becomes 0x00000000 after that edge, whatever `sel_i` holds. Reset is synchronous and active-high.
- R2: With `sel_i` = 0, the next PC is PC+4.
- R3: `pc_plus4_o` always equals `pc_o` + 4, modulo 2^32.
- R4: With `sel_i` = 1 and the branch taken, the next PC is PC+4 + (sign-extended 16-bit offset × 4). The branch is taken when `branch_ne_i`=0 and `alu_zero_i`=1, or when `branch_ne_i`=1 and `alu_zero_i`=0.
- R5: With `sel_i` = 1 and the branch not taken, the next PC is PC+4.
- R6: With `sel_i` = 2, the next PC is {PC[31:28], `jidx_i`[25:0], 2'b00}.
- R7: With `sel_i` = 3, the next PC is `rs_val_i` with bits [1:0] forced to 0.
- R8: `sel_i` = 4 loads 0x00000004 (undefined opcode). `sel_i` = 5 loads 0x00000008 (interrupt). `sel_i` = 6 loads 0x00000000 (reset vector).
- R9: The unused code `sel_i` = 7 behaves like code 0 and loads PC+4.
- R10: Bits [1:0] of `pc_o` are 0 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Next-PC source code |
| imm_i | input | 16 | Instruction offset field |
| jidx_i | input | 26 | Instruction jump index field |
| rs_val_i | input | 32 | Register read value for indirect jumps |
| alu_zero_i | input | 1 | ALU zero flag from the compare subtraction |
| branch_ne_i | input | 1 | 1 for branch-not-equal, 0 for branch-equal |
| pc_o | output | 32 | Current PC (fetch address) |
| pc_plus4_o | output | 32 | Current PC + 4 (link value) |

## Verification
Every source selection shows on `pc_o` exactly one rising edge after it is driven. The bench therefore drives inputs on the falling edge and queues the expected PC. It pops and compares that value shortly after the following rising edge. `pc_plus4_o` is combinational from the register and is compared in the same sample. The expected PC comes from a model PC in the bench, so a chain of branches, jumps and wrap-around is checked cumulatively.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
    typedef enum logic [2:0] {
        SRC_SEQ     = 3'd0,
        SRC_BRANCH  = 3'd1,
        SRC_JUMP    = 3'd2,
        SRC_REGJUMP = 3'd3,
        SRC_ILLEGAL = 3'd4,
        SRC_IRQ     = 3'd5,
        SRC_RESET   = 3'd6,
        SRC_SPARE   = 3'd7
    } pc_src_e;

    localparam logic [31:0] VEC_RESET   = 32'h0000_0000;
    localparam logic [31:0] VEC_ILLEGAL = 32'h0000_0004;
    localparam logic [31:0] VEC_IRQ     = 32'h0000_0008;
endpackage

// File: rtl/pc_incr.sv
module pc_incr #(
    parameter int W = 32
) (
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] plus4_o
);
    assign plus4_o = pc_i + W'(4);
endmodule

// File: rtl/pc_branch_target.sv
module pc_branch_target #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     plus4_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [W-1:0]     target_o
);
    localparam int EXT_W = W - IMM_W - 2;

    logic [W-1:0] offset;

    always_comb begin
        offset   = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
        target_o = plus4_i + offset;
    end
endmodule

// File: rtl/pc_source_mux.sv
module pc_source_mux
    import pc_seq_pkg::*;
#(
    parameter int          W       = 32,
    parameter int          JIDX_W  = 26,
    parameter logic [W-1:0] V_RESET = '0,
    parameter logic [W-1:0] V_ILL   = '0,
    parameter logic [W-1:0] V_IRQ   = '0
) (
    input  logic [2:0]          sel_i,
    input  logic                taken_i,
    input  logic [W-1:0]        seq_i,
    input  logic [W-1:0]        br_tgt_i,
    input  logic [W-JIDX_W-3:0] region_i,
    input  logic [JIDX_W-1:0]   jidx_i,
    input  logic [W-1:0]        rs_val_i,
    output logic [W-1:0]        next_o
);
    always_comb begin
        case (pc_src_e'(sel_i))
            SRC_BRANCH:  next_o = taken_i ? br_tgt_i : seq_i;
            SRC_JUMP:    next_o = {region_i, jidx_i, 2'b00};
            SRC_REGJUMP: next_o = rs_val_i & ~W'(3);
            SRC_ILLEGAL: next_o = V_ILL;
            SRC_IRQ:     next_o = V_IRQ;
            SRC_RESET:   next_o = V_RESET;
            default:     next_o = seq_i;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int W      = 32,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        sel_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [JIDX_W-1:0] jidx_i,
    input  logic [W-1:0]      rs_val_i,
    input  logic              alu_zero_i,
    input  logic              branch_ne_i,
    output logic [W-1:0]      pc_o,
    output logic [W-1:0]      pc_plus4_o
);
    localparam int REGION_W = W - JIDX_W - 2;

    typedef struct packed {
        logic [W-1:0] pc;
    } pc_state_t;

    pc_state_t    st_d, st_q;
    logic [W-1:0] plus4, br_tgt, mux_next;
    logic         br_taken;

    pc_incr #(.W(W)) u_incr (
        .pc_i    (st_q.pc),
        .plus4_o (plus4)
    );

    pc_branch_target #(.W(W), .IMM_W(IMM_W)) u_btgt (
        .plus4_i  (plus4),
        .imm_i    (imm_i),
        .target_o (br_tgt)
    );

    assign br_taken = alu_zero_i ^ branch_ne_i;

    pc_source_mux #(
        .W(W), .JIDX_W(JIDX_W),
        .V_RESET(W'(VEC_RESET)), .V_ILL(W'(VEC_ILLEGAL)), .V_IRQ(W'(VEC_IRQ))
    ) u_mux (
        .sel_i    (sel_i),
        .taken_i  (br_taken),
        .seq_i    (plus4),
        .br_tgt_i (br_tgt),
        .region_i (st_q.pc[W-1 -: REGION_W]),
        .jidx_i   (jidx_i),
        .rs_val_i (rs_val_i),
        .next_o   (mux_next)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = rst ? W'(VEC_RESET) : mux_next;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign pc_plus4_o = plus4;

    assert_reset_vec_R1: assert property (@(posedge clk)
        rst |=> pc_o == W'(VEC_RESET));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 3'd0) |=> pc_o == $past(pc_o) + W'(4));

    assert_link_R3: assert property (@(posedge clk) disable iff (rst)
        pc_plus4_o - pc_o == W'(4));

    assert_not_taken_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 3'd1 && alu_zero_i == branch_ne_i) |=> pc_o == $past(pc_o) + W'(4));

    assert_jump_region_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 3'd2) |=> pc_o[W-1 -: REGION_W] == $past(pc_o[W-1 -: REGION_W]));

    assert_irq_vec_R8: assert property (@(posedge clk) disable iff (rst)
        (sel_i == 3'd5) |=> pc_o == W'(VEC_IRQ));

    assert_align_R10: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);
endmodule

// File: tb/pc_sequencer_test.sv
module pc_sequencer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = '0;
    logic [15:0] imm = '0;
    logic [25:0] jidx = '0;
    logic [31:0] rsv = '0;
    logic        zf = 1'b0;
    logic        ne = 1'b0;
    logic [31:0] pc, pc4;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] model_pc = 32'h0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #5 clk = ~clk;

    pc_sequencer uut (
        .clk(clk), .rst(rst), .sel_i(sel), .imm_i(imm), .jidx_i(jidx),
        .rs_val_i(rsv), .alu_zero_i(zf), .branch_ne_i(ne),
        .pc_o(pc), .pc_plus4_o(pc4)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: drive on falling edge, push the PC due after the next rising edge
    task automatic drive(input logic r, input logic [2:0] s, input logic [15:0] im,
                         input logic [25:0] ji, input logic [31:0] rv,
                         input logic z, input logic n, input string tag);
        logic [31:0] p4, nxt;
        @(negedge clk);
        rst = r; sel = s; imm = im; jidx = ji; rsv = rv; zf = z; ne = n;
        p4 = model_pc + 32'd4;
        if (r) nxt = 32'h0;
        else case (s)
            3'd1: nxt = (z != n) ? p4 + {{14{im[15]}}, im, 2'b00} : p4;
            3'd2: nxt = {model_pc[31:28], ji, 2'b00};
            3'd3: nxt = {rv[31:2], 2'b00};
            3'd4: nxt = 32'h4;
            3'd5: nxt = 32'h8;
            3'd6: nxt = 32'h0;
            default: nxt = p4;
        endcase
        model_pc = nxt;
        exp_q.push_back(nxt);
        tag_q.push_back(tag);
    endtask

    // monitor: sample 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, pc, e);
            check("R3", pc4, e + 32'd4);
            if (t != "R1") check("R10", {30'd0, pc[1:0]}, 32'd0);
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        drive(1, 3'd2, 16'h0, 26'h3FFFFFF, 32'h0, 0, 0, "R1");     // reset wins over jump
        drive(0, 3'd0, 16'h0, 26'h0, 32'h0, 0, 0, "R2");
        drive(0, 3'd0, 16'h0, 26'h0, 32'h0, 0, 0, "R2");
        drive(0, 3'd1, 16'h0010, 26'h0, 32'h0, 1, 0, "R4");        // beq taken, forward
        drive(0, 3'd1, 16'hFFFC, 26'h0, 32'h0, 0, 1, "R4");        // bne taken, backward
        drive(0, 3'd1, 16'h0040, 26'h0, 32'h0, 0, 0, "R5");        // beq not taken
        drive(0, 3'd1, 16'h0040, 26'h0, 32'h0, 1, 1, "R5");        // bne not taken
        drive(0, 3'd3, 16'h0, 26'h0, 32'hA000_1003, 0, 0, "R7");   // low bits cleared
        drive(0, 3'd2, 16'h0, 26'h123_4567, 32'h0, 0, 0, "R6");    // keeps region A
        drive(0, 3'd1, 16'h8000, 26'h0, 32'h0, 1, 0, "R4");        // most negative offset
        drive(0, 3'd7, 16'h0, 26'h0, 32'h0, 0, 0, "R9");
        drive(0, 3'd4, 16'h0, 26'h0, 32'h0, 0, 0, "R8");
        drive(0, 3'd5, 16'h0, 26'h0, 32'h0, 0, 0, "R8");
        drive(0, 3'd3, 16'h0, 26'h0, 32'hFFFF_FFFC, 0, 0, "R7");
        drive(0, 3'd0, 16'h0, 26'h0, 32'h0, 0, 0, "R2");           // wraps to 0
        drive(0, 3'd3, 16'h0, 26'h0, 32'h5555_5554, 0, 0, "R7");
        drive(0, 3'd6, 16'h0, 26'h0, 32'h0, 0, 0, "R8");
        drive(0, 3'd3, 16'h0, 26'h0, 32'h7000_0020, 0, 0, "R7");
        drive(1, 3'd5, 16'h0, 26'h0, 32'h0, 0, 0, "R1");           // reset wins over irq
        drive(0, 3'd0, 16'h0, 26'h0, 32'h0, 0, 0, "R2");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule